// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block takes software interrupt commands issued by up to eight processors and keeps, for every software interrupt ID and every target processor, a bitmap of the processors that asked for that interrupt. A command word names the ID and selects the targets, either through an explicit list or through a filter: everyone else, the requester only, or everybody. Every selected target gets the requester's bit in its bitmap and a pending flag for that ID.

A target processor acknowledges one ID at a time. The block returns the ID together with the lowest-numbered processor still recorded in that bitmap, clears that one source bit, and drops the pending flag only after the last source has been drained. The same command port also accepts direct writes that set or clear bitmap bits for the requester's own entries. Choosing which ID to acknowledge, by priority, is left to the surrounding logic.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every pending flag is 0 and `rsp_valid` is 0.
- R2: A command word holds the ID in bits 9:0, the target filter in bits 25:24 and the explicit target list in bits 23:16. Filter value 0 selects exactly the processors whose list bit is set, and only list bits below NUM_CPU take effect.
- R3: Filter value 1 selects every processor except the requester. Filter value 2 selects only the requester. Filter value 3 selects every processor, requester included.
- R4: `cmd_op` 0 (send) ORs the requester's bit into the bitmap of the ID for each selected target and sets that entry's pending flag. A command whose ID is NUM_SGI or more changes no state, and `cmd_op` 3 changes no state.
- R5: An acknowledge of an entry with a non-empty bitmap returns, one cycle later on `rsp_word` with `rsp_valid` high, the ID in bits 9:0 and the lowest set source number in bits 12:10, and removes that source bit alone.
- R6: The pending flag of an entry stays set while any source bit remains and clears in the same update that removes the last source bit through an acknowledge.
- R7: `cmd_op` 2 (clear) ANDs the complement of bits 23:16 into the bitmap of the ID for the requester's own entry. The flag clears if the result is empty and is otherwise unchanged.
- R8: `cmd_op` 1 (set) ORs bits 23:16 into the bitmap of the ID for the requester's own entry and sets the flag, even when the value is zero.
- R9: An acknowledge of an entry with an empty bitmap, or with an ID of NUM_SGI or more, returns 1023 with source 0 and changes no bitmap or flag.
- R10: When a command and an acknowledge touch the same entry in one cycle, the command is applied first and the acknowledge sees its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 send, 1 set bitmap, 2 clear bitmap, 3 no operation |
| cmd_cpu | input | CPU_W | Requesting processor number |
| cmd_word | input | 32 | Command word |
| ack_valid | input | 1 | Acknowledge present this cycle |
| ack_cpu | input | CPU_W | Acknowledging target processor |
| ack_id | input | 10 | ID being acknowledged |
| rsp_valid | output | 1 | Acknowledge response valid |
| rsp_word | output | 13 | Source number in 12:10, ID in 9:0, 1023 when nothing pending |
| pend_flags | output | NUM_CPU*NUM_SGI | Pending flag of target t and ID i at bit t*NUM_SGI+i |

## Verification
The main instance is built with eight processors and sixteen IDs, so every filter code can select targets across the full three-bit source field, and source numbers up to 7 appear in the response. A second instance with four processors and four IDs shows that list bits above the processor count are dropped and that an ID past the last one is discarded rather than folded onto a lower ID. The vector table drives collisions of a command with an acknowledge on the same entry, draining of several sources in ascending order, and the empty-bitmap flag left by a zero-valued set write.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int CMD_W       = 32;
   localparam int ID_W        = 10;
   localparam int ID_LO       = 0;
   localparam int LIST_LO     = 16;
   localparam int LIST_W      = 8;
   localparam int FILT_LO     = 24;
   localparam int SRC_FIELD_W = 3;
   localparam int RSP_W       = ID_W + SRC_FIELD_W;
   localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

   typedef enum logic [1:0] {
      OP_SEND   = 2'd0,
      OP_SETMAP = 2'd1,
      OP_CLRMAP = 2'd2,
      OP_NONE   = 2'd3
   } sgi_op_e;

   typedef enum logic [1:0] {
      FLT_LIST   = 2'd0,
      FLT_OTHERS = 2'd1,
      FLT_SELF   = 2'd2,
      FLT_ALL    = 2'd3
   } sgi_filter_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
   import sgi_pkg::*;
#(
   parameter int NUM_CPU = 8,
   parameter int CPU_W   = 3
) (
   input  logic [1:0]         filter,
   input  logic [NUM_CPU-1:0] list,
   input  logic [CPU_W-1:0]   req,
   output logic [NUM_CPU-1:0] mask
);
   logic [NUM_CPU-1:0] self_m;

   assign self_m = NUM_CPU'(1) << req;

   always_comb begin
      unique case (sgi_filter_e'(filter))
         FLT_LIST:   mask = list;
         FLT_OTHERS: mask = ~self_m;
         FLT_SELF:   mask = self_m;
         default:    mask = '1;
      endcase
   end
endmodule

// File: rtl/sgi_lowest_src.sv
module sgi_lowest_src #(
   parameter int N = 8,
   parameter int W = 3
) (
   input  logic [N-1:0] map,
   output logic         found,
   output logic [W-1:0] idx,
   output logic [N-1:0] onehot
);
   assign found  = |map;
   assign onehot = map & (~map + N'(1));

   always_comb begin
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (map[k]) idx = W'(k);
      end
   end
endmodule

// File: rtl/sgi_entry.sv
module sgi_entry #(
   parameter int NUM_CPU = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               or_en,
   input  logic [NUM_CPU-1:0] or_val,
   input  logic               and_en,
   input  logic [NUM_CPU-1:0] and_val,
   input  logic               ack_hit,
   input  logic [NUM_CPU-1:0] ack_clr,
   output logic [NUM_CPU-1:0] merged_o,
   output logic [NUM_CPU-1:0] map_o,
   output logic               flag_o
);
   logic [NUM_CPU-1:0] map_q, map_d;
   logic               flag_q, flag_d;

   // command effect first, acknowledge second
   assign merged_o = (map_q | (or_en ? or_val : '0)) & ~(and_en ? and_val : '0);
   assign map_d    = merged_o & ~ack_clr;

   always_comb begin
      flag_d = flag_q;
      if (or_en) flag_d = 1'b1;
      if (and_en && (merged_o == '0)) flag_d = 1'b0;
      if (ack_hit && (|ack_clr) && (map_d == '0)) flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         map_q  <= map_d;
         flag_q <= flag_d;
      end
   end

   assign map_o  = map_q;
   assign flag_o = flag_q;

   assert_map_implies_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (map_q != '0) |-> flag_q);

   assert_ack_drains_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && (map_q != '0) && !or_en && !and_en)
      |=> ($countones(map_q) + 1 == $countones($past(map_q))));

   assert_empty_ack_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && (map_q == '0) && !or_en && !and_en)
      |=> ((map_q == '0) && (flag_q == $past(flag_q))));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int NUM_CPU = 8,
   parameter int NUM_SGI = 16,
   localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [1:0]                 cmd_op,
   input  logic [CPU_W-1:0]           cmd_cpu,
   input  logic [CMD_W-1:0]           cmd_word,
   input  logic                       ack_valid,
   input  logic [CPU_W-1:0]           ack_cpu,
   input  logic [ID_W-1:0]            ack_id,
   output logic                       rsp_valid,
   output logic [RSP_W-1:0]           rsp_word,
   output logic [NUM_CPU*NUM_SGI-1:0] pend_flags
);
   localparam int NUM_ENT = NUM_CPU * NUM_SGI;

   if (NUM_CPU < 1 || NUM_CPU > LIST_W) begin : g_bad_cpu
      $error("sgi_dispatch: NUM_CPU must lie in 1..8");
   end
   if (NUM_SGI < 1 || NUM_SGI > 1023) begin : g_bad_sgi
      $error("sgi_dispatch: NUM_SGI must lie in 1..1023");
   end

   logic [ID_W-1:0]    cmd_id;
   logic [NUM_CPU-1:0] cmd_list;
   logic [1:0]         cmd_filter;
   logic               id_ok, send_go, set_go, clr_go;
   logic [NUM_CPU-1:0] tmask, src_bit, or_val;
   logic               unused_word;

   assign cmd_id      = cmd_word[ID_LO +: ID_W];
   assign cmd_list    = cmd_word[LIST_LO +: NUM_CPU];
   assign cmd_filter  = cmd_word[FILT_LO +: 2];
   assign unused_word = ^cmd_word;

   assign id_ok   = (32'(cmd_id) < NUM_SGI);
   assign send_go = cmd_valid && id_ok && (sgi_op_e'(cmd_op) == OP_SEND);
   assign set_go  = cmd_valid && id_ok && (sgi_op_e'(cmd_op) == OP_SETMAP);
   assign clr_go  = cmd_valid && id_ok && (sgi_op_e'(cmd_op) == OP_CLRMAP);
   assign src_bit = NUM_CPU'(1) << cmd_cpu;
   assign or_val  = send_go ? src_bit : cmd_list;

   sgi_target_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_decode (
      .filter (cmd_filter),
      .list   (cmd_list),
      .req    (cmd_cpu),
      .mask   (tmask)
   );

   logic [NUM_ENT-1:0] ent_or_en, ent_and_en, ent_ack_hit;
   logic [NUM_CPU-1:0] ent_merged [NUM_ENT];
   logic [NUM_CPU-1:0] ent_map    [NUM_ENT];
   logic [NUM_CPU-1:0] pick_map, pick_onehot;
   logic [CPU_W-1:0]   pick_idx;
   logic               pick_found;

   for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
      for (genvar i = 0; i < NUM_SGI; i++) begin : g_id
         localparam int E = t * NUM_SGI + i;
         logic id_match, tgt_self;

         assign id_match = (cmd_id == ID_W'(i));
         assign tgt_self = (cmd_cpu == CPU_W'(t));
         assign ent_or_en[E]   = id_match && ((send_go && tmask[t]) || (set_go && tgt_self));
         assign ent_and_en[E]  = id_match && clr_go && tgt_self;
         assign ent_ack_hit[E] = ack_valid && (ack_id == ID_W'(i)) && (ack_cpu == CPU_W'(t));

         sgi_entry #(.NUM_CPU(NUM_CPU)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .or_en    (ent_or_en[E]),
            .or_val   (or_val),
            .and_en   (ent_and_en[E]),
            .and_val  (cmd_list),
            .ack_hit  (ent_ack_hit[E]),
            .ack_clr  (ent_ack_hit[E] ? pick_onehot : '0),
            .merged_o (ent_merged[E]),
            .map_o    (ent_map[E]),
            .flag_o   (pend_flags[E])
         );
      end
   end

   always_comb begin
      pick_map = '0;
      for (int e = 0; e < NUM_ENT; e++) begin
         if (ent_ack_hit[e]) pick_map = ent_merged[e];
      end
   end

   sgi_lowest_src #(.N(NUM_CPU), .W(CPU_W)) u_pick (
      .map    (pick_map),
      .found  (pick_found),
      .idx    (pick_idx),
      .onehot (pick_onehot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_word  <= '0;
      end else begin
         rsp_valid <= ack_valid;
         if (ack_valid) begin
            rsp_word <= pick_found ? {SRC_FIELD_W'(pick_idx), ack_id}
                                   : {SRC_FIELD_W'(0), NO_IRQ};
         end
      end
   end

   assert_rsp_follows_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> rsp_valid);

   assert_no_rsp_without_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_valid |=> !rsp_valid);

   assert_src_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_word[ID_W-1:0] != NO_IRQ))
      |-> (32'(rsp_word[RSP_W-1:ID_W]) < NUM_CPU));

   assert_spurious_src_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_word[ID_W-1:0] == NO_IRQ)) |-> (rsp_word[RSP_W-1:ID_W] == '0));
endmodule

// File: tb/tb_sgi_dispatch.sv
`timescale 1ns/1ps
module tb_sgi_dispatch;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [2:0]  cmd_cpu = 3'd0;
   logic [31:0] cmd_word = 32'd0;
   logic        ack_valid = 1'b0;
   logic [2:0]  ack_cpu = 3'd0;
   logic [9:0]  ack_id = 10'd0;
   logic        rsp_valid;
   logic [12:0] rsp_word;
   logic [127:0] pend_flags;

   sgi_dispatch #(.NUM_CPU(8), .NUM_SGI(16)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_cpu(cmd_cpu), .cmd_word(cmd_word), .ack_valid(ack_valid),
      .ack_cpu(ack_cpu), .ack_id(ack_id), .rsp_valid(rsp_valid),
      .rsp_word(rsp_word), .pend_flags(pend_flags)
   );

   logic        s_cmd_valid = 1'b0;
   logic [1:0]  s_cmd_cpu = 2'd0;
   logic [31:0] s_cmd_word = 32'd0;
   logic        s_rsp_valid;
   logic [12:0] s_rsp_word;
   logic [15:0] s_pend;

   sgi_dispatch #(.NUM_CPU(4), .NUM_SGI(4)) dut_small (
      .clk(clk), .rst_n(rst_n), .cmd_valid(s_cmd_valid), .cmd_op(2'd0),
      .cmd_cpu(s_cmd_cpu), .cmd_word(s_cmd_word), .ack_valid(1'b0),
      .ack_cpu(2'd0), .ack_id(10'd0), .rsp_valid(s_rsp_valid),
      .rsp_word(s_rsp_word), .pend_flags(s_pend)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic [3:0]  req;
      logic        cmdv;
      logic [1:0]  op;
      logic [2:0]  cpu;
      logic [31:0] word;
      logic        ackv;
      logic [2:0]  acpu;
      logic [3:0]  aid;
      logic [12:0] rsp;
      logic [2:0]  ct;
      logic [3:0]  ci;
      logic        cf;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      // R2 list 0x06 from cpu5, id 3
      '{4'd2, 1'b1, 2'd0, 3'd5, 32'h0006_0003, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd1, 4'd3, 1'b1},
      // R4 second source cpu2 for target 1
      '{4'd4, 1'b1, 2'd0, 3'd2, 32'h0002_0003, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd2, 4'd3, 1'b1},
      // R5 lowest source 2 first
      '{4'd5, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd1, 4'd3, 13'h0803, 3'd1, 4'd3, 1'b1},
      // R6 last source 5 drops flag
      '{4'd6, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd1, 4'd3, 13'h1403, 3'd1, 4'd3, 1'b0},
      // R9 empty map
      '{4'd9, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd1, 4'd3, 13'h03FF, 3'd1, 4'd3, 1'b0},
      // R3 filter 1 excludes requester 0
      '{4'd3, 1'b1, 2'd0, 3'd0, 32'h0100_0007, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd0, 4'd7, 1'b0},
      // R3 filter 1 reached target 7
      '{4'd3, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd7, 4'd7, 13'h0007, 3'd7, 4'd7, 1'b0},
      // R3 filter 1 reached target 6
      '{4'd3, 1'b0, 2'd0, 3'd0, 32'h0,         1'b0, 3'd0, 4'd0, 13'h0000, 3'd6, 4'd7, 1'b1},
      // R3 filter 2 self
      '{4'd3, 1'b1, 2'd0, 3'd4, 32'h0200_0009, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd4, 4'd9, 1'b1},
      // R3 filter 2 did not reach cpu3
      '{4'd3, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd3, 4'd9, 13'h03FF, 3'd3, 4'd9, 1'b0},
      // R3 filter 3 all, list ignored
      '{4'd3, 1'b1, 2'd0, 3'd6, 32'h0301_000F, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd0, 4'd15, 1'b1},
      // R3 filter 3 includes requester
      '{4'd3, 1'b0, 2'd0, 3'd0, 32'h0,         1'b0, 3'd0, 4'd0, 13'h0000, 3'd6, 4'd15, 1'b1},
      // R10 command and ack on same entry
      '{4'd10,1'b1, 2'd0, 3'd1, 32'h0008_000C, 1'b1, 3'd3, 4'd12,13'h040C, 3'd3, 4'd12, 1'b0},
      // R8 set bitmap 0x90
      '{4'd8, 1'b1, 2'd1, 3'd2, 32'h0090_0004, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd2, 4'd4, 1'b1},
      // R7 clear source 4, 7 remains
      '{4'd7, 1'b1, 2'd2, 3'd2, 32'h0010_0004, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd2, 4'd4, 1'b1},
      // R5 remaining source 7
      '{4'd5, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd2, 4'd4, 13'h1C04, 3'd2, 4'd4, 1'b0},
      // R8 zero-valued set raises flag
      '{4'd8, 1'b1, 2'd1, 3'd6, 32'h0000_0002, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd6, 4'd2, 1'b1},
      // R9 ack of empty map keeps flag
      '{4'd9, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd6, 4'd2, 13'h03FF, 3'd6, 4'd2, 1'b1},
      // R7 zero clear on empty map drops flag
      '{4'd7, 1'b1, 2'd2, 3'd6, 32'h0000_0002, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd6, 4'd2, 1'b0},
      // R4 id 16 out of range, id 0 untouched
      '{4'd4, 1'b1, 2'd0, 3'd0, 32'h0200_0010, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd0, 4'd0, 1'b0},
      // R4 op 3 no effect
      '{4'd4, 1'b1, 2'd3, 3'd0, 32'h0201_0005, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd0, 4'd5, 1'b0},
      // R5 source 3 arrives first
      '{4'd5, 1'b1, 2'd0, 3'd3, 32'h0001_0000, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd0, 4'd0, 1'b1},
      // R5 source 0 arrives second
      '{4'd5, 1'b1, 2'd0, 3'd0, 32'h0001_0000, 1'b0, 3'd0, 4'd0, 13'h0000, 3'd0, 4'd0, 1'b1},
      // R5 source 0 returned first
      '{4'd5, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd0, 4'd0, 13'h0000, 3'd0, 4'd0, 1'b1},
      // R6 then source 3, flag drops
      '{4'd6, 1'b0, 2'd0, 3'd0, 32'h0,         1'b1, 3'd0, 4'd0, 13'h0C00, 3'd0, 4'd0, 1'b0}
   };

   task automatic idle();
      cmd_valid = 1'b0; ack_valid = 1'b0; s_cmd_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(pend_flags == '0, "R1 flags", 32'(|pend_flags), 32'd0);
      check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
      @(negedge clk); rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         cmd_valid = VEC[v].cmdv; cmd_op = VEC[v].op; cmd_cpu = VEC[v].cpu;
         cmd_word = VEC[v].word; ack_valid = VEC[v].ackv; ack_cpu = VEC[v].acpu;
         ack_id = 10'(VEC[v].aid);
         @(posedge clk); #1;
         check(pend_flags[int'(VEC[v].ct)*16 + int'(VEC[v].ci)] == VEC[v].cf,
               $sformatf("R%0d row %0d flag", VEC[v].req, v),
               32'(pend_flags[int'(VEC[v].ct)*16 + int'(VEC[v].ci)]), 32'(VEC[v].cf));
         if (VEC[v].ackv)
            check(rsp_valid && rsp_word == VEC[v].rsp,
                  $sformatf("R%0d row %0d rsp", VEC[v].req, v),
                  32'(rsp_word), 32'(VEC[v].rsp));
         else
            check(!rsp_valid, $sformatf("R5 row %0d no rsp", v), 32'(rsp_valid), 32'd0);
      end
      @(negedge clk); idle();

      // R9 ack of an ID beyond the last one
      @(negedge clk); ack_valid = 1'b1; ack_cpu = 3'd0; ack_id = 10'd20;
      @(posedge clk); #1;
      check(rsp_valid && rsp_word == 13'h03FF, "R9 id out of range", 32'(rsp_word), 32'h3FF);
      @(negedge clk); idle();

      // R2 small build: list bits above NUM_CPU dropped
      @(negedge clk); s_cmd_valid = 1'b1; s_cmd_cpu = 2'd1; s_cmd_word = 32'h00FF_0002;
      @(posedge clk); #1;
      check(s_pend == 16'h4444, "R2 small list", 32'(s_pend), 32'h4444);
      // R4 small build: id 5 not folded onto id 1
      @(negedge clk); s_cmd_word = 32'h00FF_0005;
      @(posedge clk); #1;
      check(s_pend == 16'h4444, "R4 small id range", 32'(s_pend), 32'h4444);
      @(negedge clk); idle();

      // R1 reset with state present clears it
      check(pend_flags != '0, "R1 pre-reset state", 32'(|pend_flags), 32'd1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check(pend_flags == '0 && s_pend == '0, "R1 reset clears", 32'(|pend_flags), 32'd0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule